// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It runs on the high-rate input clock. It contains a model of a dual-modulus prescaler that divides by 64 or by 65. Two counters sit on the prescaler's output: a 6-bit swallow counter and a 12-bit main counter. The swallow counter keeps the prescaler at divide-by-65 for the first A prescaler cycles of each period. The main counter counts the whole period of N prescaler cycles. The division ratio is therefore N x 64 + A input clocks.

When the main counter finishes its last prescaler cycle, the block does three things in that one clock cycle. It emits a single-cycle output pulse, it reloads both counters from the programmed values, and it raises a load-active flag. A register block can watch that flag to avoid changing the programmed values during the reload. Values presented at any other time wait for the next reload and do not disturb the period in progress.

Top module: `pswallow_divider`

## Requirements
- R1: While reset is held, `div_out_o`, `load_active_o` and `modsel_o` are all 0, with 0 on `modsel_o` meaning divide-by-64.
- R2: After reset, both counters start empty. The first output pulse is therefore visible after exactly 63 rising clock edges following reset release, which completes one 64-cycle prescaler period.
- R3: With 1 <= N and A <= N, the distance between consecutive output pulses is N x 64 + A clock cycles.
- R4: With A = 0, `modsel_o` stays 0 (divide-by-64) for the entire period.
- R5: In each period, `modsel_o` (1 = divide-by-65) is 1 for exactly A x 65 clock cycles. These cycles are the first A prescaler cycles after the reload, and `modsel_o` changes only in the clock cycle after a prescaler terminal count.
- R6: `div_out_o` is high for a single clock cycle per period.
- R7: `load_active_o` is high in exactly the cycles where the counters reload, which are the cycles in which `div_out_o` is high.
- R8: Changing `swallow_i` or `main_i` in the middle of a period does not alter that period. The new values take effect only from the next reload.
- R9: A programmed N of 0 divides as if N were 1. With A = 0, this gives a period of 64 cycles.
- R10: With A = N, every prescaler cycle of the period divides by 65. `modsel_o` is then 1 throughout the period, and the period is N x 65.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock (the prescaler input) |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_i | input | 6 | Programmed swallow count A |
| main_i | input | 12 | Programmed main count N |
| modsel_o | output | 1 | Modulus control: 1 = divide-by-65, 0 = divide-by-64 |
| load_active_o | output | 1 | High during the reload cycle |
| div_out_o | output | 1 | One-cycle pulse per full division period |

## Verification
Several properties are checked on every cycle. The prescaler count stays within its 65-state range. The modulus control changes only right after a prescaler terminal count. The output pulse never lasts two cycles. After each reload, both counters hold the values that were present on the inputs at that reload. Some behaviours only the bench's scenarios can show: the exact period length for each (N, A) pair, the number of divide-by-65 cycles per period, the deferred effect of a change in the middle of a period, and the latency from reset release to the first pulse.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
    // log2 of the prescaler base modulus (base 64, extended modulus 65)
    localparam int DEF_PS_W = 6;
    // swallow counter width
    localparam int DEF_A_W  = 6;
    // main counter width
    localparam int DEF_N_W  = 12;
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
    parameter int PS_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi_i,
    output logic tick_o
);
    localparam int CW = PS_W + 1;
    localparam logic [CW-1:0] LIM_HI = CW'(2 ** PS_W);
    localparam logic [CW-1:0] LIM_LO = CW'(2 ** PS_W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d   = st_q;
        limit  = mod_hi_i ? LIM_HI : LIM_LO;
        tick_o = (st_q.cnt == limit);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM_HI);

    // R3
    wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == '0));
endmodule

// File: rtl/pswallow_acnt.sv
module pswallow_acnt #(
    parameter int A_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           reload_i,
    input  logic [A_W-1:0] load_val_i,
    output logic           mod_hi_o
);
    typedef struct packed {
        logic [A_W-1:0] left;
    } a_state_t;

    a_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        mod_hi_o = (st_q.left != '0);
        if (reload_i)
            st_d.left = load_val_i;
        else if (tick_i && mod_hi_o)
            st_d.left = st_q.left - A_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    a_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.left == $past(load_val_i)));

    // R5
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !reload_i) |=> $stable(st_q.left));
endmodule

// File: rtl/pswallow_ncnt.sv
module pswallow_ncnt #(
    parameter int N_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [N_W-1:0] load_val_i,
    output logic           last_o
);
    localparam logic [N_W-1:0] ONE = N_W'(1);

    typedef struct packed {
        logic [N_W-1:0] left;
    } n_state_t;

    n_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        // a count of 0 or 1 both mean this prescaler cycle is the last one
        last_o = tick_i && (st_q.left <= ONE);
        if (last_o)
            st_d.left = load_val_i;
        else if (tick_i)
            st_d.left = st_q.left - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.left <= ONE;
        else        st_q <= st_d;
    end

    // R8
    n_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (st_q.left == $past(load_val_i)));

    // R3
    n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.left));
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int PS_W = DEF_PS_W,
    parameter int A_W  = DEF_A_W,
    parameter int N_W  = DEF_N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_i,
    input  logic [N_W-1:0] main_i,
    output logic           modsel_o,
    output logic           load_active_o,
    output logic           div_out_o
);
    logic ps_tick;
    logic mod_hi;
    logic reload;

    pswallow_prescaler #(.PS_W(PS_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_hi_i (mod_hi),
        .tick_o   (ps_tick)
    );

    pswallow_acnt #(.A_W(A_W)) u_acnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ps_tick),
        .reload_i   (reload),
        .load_val_i (swallow_i),
        .mod_hi_o   (mod_hi)
    );

    pswallow_ncnt #(.N_W(N_W)) u_ncnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ps_tick),
        .load_val_i (main_i),
        .last_o     (reload)
    );

    always_comb begin
        modsel_o      = mod_hi;
        load_active_o = reload;
        div_out_o     = reload;
    end

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out_o |=> !div_out_o);

    // R5
    modsel_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> $stable(modsel_o));

    // R7
    reload_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_active_o |-> ps_tick);
endmodule

// File: tb/pswallow_divider_test.sv
module pswallow_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  swallow = '0;
    logic [11:0] main_n = 12'd1;
    logic        modsel, load_active, div_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pswallow_divider uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .swallow_i     (swallow),
        .main_i        (main_n),
        .modsel_o      (modsel),
        .load_active_o (load_active),
        .div_out_o     (div_out)
    );

    function automatic int exp_period(int n, int a);
        int nn = (n == 0) ? 1 : n;
        return nn * 64 + a;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_out);
    endtask

    // Counts cycles from the cycle after a pulse up to and including the next pulse.
    task automatic measure(output int per, output int hi, output int bad);
        per = 0; hi = 0; bad = 0;
        do begin
            @(negedge clk);
            per++;
            if (modsel) hi++;
            if (load_active != div_out) bad++;
            if (per == 1 && div_out) bad++;
        end while (!div_out);
    endtask

    task automatic t_reset();
        int edges;
        chk(div_out == 1'b0,     "R1 div_out in reset", int'(div_out), 0);
        chk(load_active == 1'b0, "R1 load_active in reset", int'(load_active), 0);
        chk(modsel == 1'b0,      "R1 modsel in reset", int'(modsel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        do begin @(negedge clk); edges++; end while (!div_out);
        chk(edges == 63, "R2 first pulse latency", edges, 63);
    endtask

    task automatic run_cfg(int n, int a, string tag);
        int per, hi, bad, ep;
        @(negedge clk);
        main_n  = 12'(n);
        swallow = 6'(a);
        wait_pulse();
        measure(per, hi, bad);
        ep = exp_period(n, a);
        chk(per == ep, {tag, " R3 period"}, per, ep);
        chk(hi == a * 65, {tag, " R5 modsel high cycles"}, hi, a * 65);
        chk(bad == 0, {tag, " R6 R7 pulse width and load flag"}, bad, 0);
    endtask

    task automatic t_zero_swallow();
        int per, hi, bad;
        @(negedge clk);
        main_n = 12'd10; swallow = 6'd0;
        wait_pulse();
        measure(per, hi, bad);
        chk(hi == 0, "R4 modsel stays low with A=0", hi, 0);
        chk(per == 640, "R4 period with A=0", per, 640);
    endtask

    task automatic t_all_swallow();
        int per, hi, bad;
        @(negedge clk);
        main_n = 12'd8; swallow = 6'd8;
        wait_pulse();
        measure(per, hi, bad);
        chk(per == 8 * 65, "R10 period with A=N", per, 520);
        chk(hi == per, "R10 modsel high whole period", hi, per);
    endtask

    task automatic t_zero_main();
        int per, hi, bad;
        @(negedge clk);
        main_n = 12'd0; swallow = 6'd0;
        wait_pulse();
        measure(per, hi, bad);
        chk(per == 64, "R9 N=0 acts as N=1", per, 64);
    endtask

    task automatic t_mid_change();
        int per, hi, bad;
        @(negedge clk);
        main_n = 12'd5; swallow = 6'd3;
        wait_pulse();
        per = 0;
        do begin
            @(negedge clk);
            per++;
            if (per == 100) begin main_n = 12'd7; swallow = 6'd1; end
        end while (!div_out);
        chk(per == exp_period(5, 3), "R8 period unchanged by mid-period write", per, exp_period(5, 3));
        measure(per, hi, bad);
        chk(per == exp_period(7, 1), "R8 new values after reload", per, exp_period(7, 1));
        chk(hi == 65, "R8 new swallow after reload", hi, 65);
    endtask

    initial begin
        #1;
        t_reset();
        run_cfg(3, 2, "cfg3_2");
        run_cfg(100, 63, "cfg100_63");
        run_cfg(1, 0, "cfg1_0");
        run_cfg(2, 1, "cfg2_1");
        t_zero_swallow();
        t_all_swallow();
        t_zero_main();
        t_mid_change();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule